// File: doc/BRIEF.md
# Binary Neuron Block Array

This block is a digital bank of binary neuron units. Each unit holds a row of binary weights and takes a row of binary inputs, with bit value 1 standing for +1 and 0 for -1. It counts how often input and weight agree, turns the count into a signed dot product, and multiplies that by a selectable power-of-two fraction. Neighbouring units can be chained into one larger neuron. Every unit in a chain then reports the chain total and compares it against its own threshold, so each unit gives one output bit.

Chaining serves three purposes. Units with scale 1 form long neurons, up to NB x CONN connections. Four units with scales 1, 1/2, 1/4 and 1/8 form one 4-bit weight per input position. Units that share a chain total but have different thresholds give a multi-level transfer function, such as a thermometer-coded quantiser.

Weights and configuration are written one unit at a time. An evaluation is started with a one-cycle strobe. The result appears two clock edges later, and a new evaluation can start on every cycle.

Top module: `neuronBlockArray`

## Requirements
- R1: Bit value 1 encodes +1 and bit value 0 encodes -1. A connection contributes +1 when its input bit equals its weight bit and -1 otherwise. A unit's raw sum is 2*matches - CONN.
- R2: Each GW-bit slice `neuronSum[i*GW +: GW]` is a two's-complement value in eighths (three fractional bits). Because raw sums are even, its least significant bit is always 0 in a result.
- R3: Scale code 0, 1, 2 and 3 multiplies a unit's raw sum by 1, 1/2, 1/4 and 1/8, with no rounding. Four chained units with codes 0 to 3 form a 4-bit weight.
- R4: Setting the chain bit of unit i joins unit i with unit i+1. Every unit in a run of joined units reports the same total, which is the sum of their scaled sums. The chain bit of the last unit has no effect.
- R5: With all chain bits set, the array acts as a single neuron of NB*CONN connections. With all inputs matching, each unit reports 8*NB*CONN.
- R6: `outBits[i]` is 1 exactly when unit i's reported total is greater than or equal to its threshold, compared as signed values in the same eighths format.
- R7: `outValid` is high for one cycle, two rising edges after the edge that samples `evalStart`. Starts on consecutive cycles each give their own result on consecutive cycles.
- R8: `outBits` and `neuronSum` keep their values between results, whatever happens on the inputs or the write ports.
- R9: A weight write on the same edge that samples `evalStart` does not affect that evaluation. It does affect the next one.
- R10: After reset the outputs are 0, every weight bit is 0, scales are 1, no units are chained, and every threshold is 0.
- R11: Units that share one chain total and have ascending thresholds give a thermometer code on their output bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wgtWrEn | input | 1 | Weight write strobe |
| wgtWrBlk | input | BIW (3) | Unit index for the weight write |
| wgtWrData | input | CONN (128) | Weight row, bit k for connection k |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrBlk | input | BIW (3) | Unit index for the configuration write |
| cfgScale | input | 2 | Scale code, 0 to 3 |
| cfgJoin | input | 1 | Chain this unit with the next one |
| cfgRef | input | GW (16) | Signed threshold in eighths |
| inData | input | NB*CONN (1024) | Input rows, unit i at bits i*CONN +: CONN |
| evalStart | input | 1 | Start an evaluation |
| outValid | output | 1 | Result strobe |
| outBits | output | NB (8) | Threshold output of each unit |
| neuronSum | output | NB*GW (128) | Chain total seen by each unit, in eighths |

## Verification
The dot product is exercised with all-match, all-mismatch, half-match and odd-count rows. Together these separate a wrong sign from a wrong offset or an off-by-one in the count. Scale codes are applied to both positive and negative sums, which shows whether the shift keeps the sign and whether any fraction is lost. The chain patterns mix isolated units, runs of different lengths, a set chain bit on the last unit, a fully joined array and a 4-bit weight group. Thresholds placed exactly at, one eighth above and one eighth below a total check the comparison boundary. Ascending thresholds on a shared total must give a thermometer code. Back-to-back starts, a weight write on the same edge as a start, and idle cycles with changing inputs check the timing of results.

// File: rtl/nbaPkg.sv
package nbaPkg;

  // Fractional bits kept on every scaled sum so 1/8 is exact
  localparam int FRAC_BITS = 3;

  typedef logic [1:0] scaleCode_t;

  // Per-unit configuration held in the datapath
  typedef struct packed {
    scaleCode_t scale;
    logic       joinNext;
  } blkCfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capSum;  // latch scaled unit sums
    logic capOut;  // latch chain totals and compare results
  } nbaStrobes_t;

endpackage

// File: rtl/nbaBlockSum.sv
module nbaBlockSum
  import nbaPkg::*;
#(
  parameter int CONN = 128,
  localparam int BW  = $clog2(CONN + 1) + 2 + FRAC_BITS
) (
  input  logic [CONN-1:0]       inBits,
  input  logic [CONN-1:0]       wgtBits,
  input  scaleCode_t            scaleSel,
  output logic signed [BW-1:0]  scaled
);

  localparam int CW   = $clog2(CONN + 1);
  localparam int SUMW = CW + 2;

  logic [CW-1:0]              matchCnt;
  logic signed [SUMW-1:0]     rawSum;
  logic signed [BW-1:0]       fixedSum;

  // Count agreeing input/weight pairs (product = +1)
  always_comb begin
    matchCnt = '0;
    for (int k = 0; k < CONN; k++) begin
      matchCnt = matchCnt + CW'(inBits[k] ~^ wgtBits[k]);
    end
  end

  // 2*matches - CONN
  assign rawSum   = $signed({1'b0, matchCnt, 1'b0}) - $signed(SUMW'(CONN));
  assign fixedSum = {rawSum, {FRAC_BITS{1'b0}}};
  assign scaled   = fixedSum >>> scaleSel;

endmodule

// File: rtl/nbaDatapath.sv
module nbaDatapath
  import nbaPkg::*;
#(
  parameter int NB   = 8,
  parameter int CONN = 128,
  parameter int BIW  = 3,
  parameter int GW   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  nbaStrobes_t          strobes,
  input  logic                 wgtWrEn,
  input  logic [BIW-1:0]       wgtWrBlk,
  input  logic [CONN-1:0]      wgtWrData,
  input  logic                 cfgWrEn,
  input  logic [BIW-1:0]       cfgWrBlk,
  input  scaleCode_t           cfgScale,
  input  logic                 cfgJoin,
  input  logic [GW-1:0]        cfgRef,
  input  logic [NB*CONN-1:0]   inData,
  output logic [NB-1:0]        outBits,
  output logic [NB*GW-1:0]     neuronSum
);

  localparam int BW = $clog2(CONN + 1) + 2 + FRAC_BITS;

  logic [NB-1:0][CONN-1:0]  wgtMem;
  blkCfg_t [NB-1:0]         cfgMem;
  logic [NB-1:0][GW-1:0]    refMem;
  logic [NB-1:0][BW-1:0]    scaledReg;
  logic [NB-1:0]            bitsReg;
  logic [NB-1:0][GW-1:0]    sumReg;

  logic signed [BW-1:0]     scaledNow [NB];
  logic signed [GW-1:0]     fwd [NB];
  logic signed [GW-1:0]     tot [NB];

  // One dot-product unit and its storage per block
  for (genvar i = 0; i < NB; i++) begin : g_blk
    nbaBlockSum #(.CONN(CONN)) u_sum (
      .inBits  (inData[i*CONN +: CONN]),
      .wgtBits (wgtMem[i]),
      .scaleSel(cfgMem[i].scale),
      .scaled  (scaledNow[i])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wgtMem[i]    <= '0;
        cfgMem[i]    <= '0;
        refMem[i]    <= '0;
        scaledReg[i] <= '0;
      end else begin
        if (wgtWrEn && wgtWrBlk == BIW'(i)) begin
          wgtMem[i] <= wgtWrData;
        end
        if (cfgWrEn && cfgWrBlk == BIW'(i)) begin
          cfgMem[i].scale    <= cfgScale;
          cfgMem[i].joinNext <= cfgJoin;
          refMem[i]          <= cfgRef;
        end
        if (strobes.capSum) begin
          scaledReg[i] <= scaledNow[i];
        end
      end
    end
  end

  // Chain totals: forward running sums, then spread each run's total back
  always_comb begin
    fwd[0] = GW'($signed(scaledReg[0]));
    for (int i = 1; i < NB; i++) begin
      if (cfgMem[i-1].joinNext) begin
        fwd[i] = fwd[i-1] + GW'($signed(scaledReg[i]));
      end else begin
        fwd[i] = GW'($signed(scaledReg[i]));
      end
    end
    tot[NB-1] = fwd[NB-1];
    for (int i = NB - 2; i >= 0; i--) begin
      if (cfgMem[i].joinNext) begin
        tot[i] = tot[i+1];
      end else begin
        tot[i] = fwd[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitsReg <= '0;
      sumReg  <= '0;
    end else if (strobes.capOut) begin
      for (int i = 0; i < NB; i++) begin
        bitsReg[i] <= (tot[i] >= $signed(refMem[i]));
        sumReg[i]  <= tot[i];
      end
    end
  end

  assign outBits   = bitsReg;
  assign neuronSum = sumReg;

endmodule

// File: rtl/nbaControl.sv
module nbaControl
  import nbaPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evalStart,
  output nbaStrobes_t strobes,
  output logic        outValid
);

  logic pend;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend     <= 1'b0;
      outValid <= 1'b0;
    end else begin
      pend     <= evalStart;
      outValid <= pend;
    end
  end

  assign strobes.capSum = evalStart;
  assign strobes.capOut = pend;

endmodule

// File: rtl/neuronBlockArray.sv
module neuronBlockArray
  import nbaPkg::*;
#(
  parameter int NB   = 8,
  parameter int CONN = 128,
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1,
  localparam int GW  = $clog2(CONN + 1) + 2 + FRAC_BITS + $clog2(NB)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wgtWrEn,
  input  logic [BIW-1:0]     wgtWrBlk,
  input  logic [CONN-1:0]    wgtWrData,
  input  logic               cfgWrEn,
  input  logic [BIW-1:0]     cfgWrBlk,
  input  logic [1:0]         cfgScale,
  input  logic               cfgJoin,
  input  logic [GW-1:0]      cfgRef,
  input  logic [NB*CONN-1:0] inData,
  input  logic               evalStart,
  output logic               outValid,
  output logic [NB-1:0]      outBits,
  output logic [NB*GW-1:0]   neuronSum
);

  nbaStrobes_t strobes;

  nbaControl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evalStart(evalStart),
    .strobes  (strobes),
    .outValid (outValid)
  );

  nbaDatapath #(.NB(NB), .CONN(CONN), .BIW(BIW), .GW(GW)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wgtWrEn  (wgtWrEn),
    .wgtWrBlk (wgtWrBlk),
    .wgtWrData(wgtWrData),
    .cfgWrEn  (cfgWrEn),
    .cfgWrBlk (cfgWrBlk),
    .cfgScale (cfgScale),
    .cfgJoin  (cfgJoin),
    .cfgRef   (cfgRef),
    .inData   (inData),
    .outBits  (outBits),
    .neuronSum(neuronSum)
  );

endmodule

// File: rtl/nbaChecker.sv
module nbaChecker #(
  parameter int NB = 8,
  parameter int GW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             evalStart,
  input logic             outValid,
  input logic [NB-1:0]    outBits,
  input logic [NB*GW-1:0] neuronSum
);

  // R7: every start yields a result strobe two edges later
  p_valid_after_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    evalStart |=> ##1 outValid);

  // R7: no result strobe without a start two cycles before
  p_valid_has_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(evalStart, 2));

  // R8: results hold while no new result is presented
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outBits) && $stable(neuronSum)));

  // R2: raw sums are even, so the 1/8 bit of a result is always clear
  for (genvar i = 0; i < NB; i++) begin : g_lsb
    p_even_lsb_r2: assert property (@(posedge clk) disable iff (!rstN)
      outValid |-> !neuronSum[i*GW]);
  end

endmodule

bind neuronBlockArray nbaChecker #(.NB(NB), .GW(GW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .evalStart(evalStart),
  .outValid (outValid),
  .outBits  (outBits),
  .neuronSum(neuronSum)
);

// File: tb/neuronBlockArray_tb.sv
`timescale 1ns/1ps
module neuronBlockArray_tb;

  localparam int NB   = 8;
  localparam int CONN = 128;
  localparam int BIW  = 3;
  localparam int GW   = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               wgtWrEn = 1'b0;
  logic [BIW-1:0]     wgtWrBlk = '0;
  logic [CONN-1:0]    wgtWrData = '0;
  logic               cfgWrEn = 1'b0;
  logic [BIW-1:0]     cfgWrBlk = '0;
  logic [1:0]         cfgScale = '0;
  logic               cfgJoin = 1'b0;
  logic [GW-1:0]      cfgRef = '0;
  logic [NB*CONN-1:0] inData = '0;
  logic               evalStart = 1'b0;
  logic               outValid;
  logic [NB-1:0]      outBits;
  logic [NB*GW-1:0]   neuronSum;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench-side mirror of everything written to the design
  logic [CONN-1:0] wM [NB];
  logic [CONN-1:0] iM [NB];
  int              scM [NB];
  bit              jM [NB];
  int              refM [NB];
  int              expTot [NB];
  int              expOut [NB];
  int              keepTot [NB];
  int              keepOut [NB];

  always #10 clk = ~clk;

  neuronBlockArray #(.NB(NB), .CONN(CONN)) u_dut (
    .clk(clk), .rstN(rstN),
    .wgtWrEn(wgtWrEn), .wgtWrBlk(wgtWrBlk), .wgtWrData(wgtWrData),
    .cfgWrEn(cfgWrEn), .cfgWrBlk(cfgWrBlk), .cfgScale(cfgScale),
    .cfgJoin(cfgJoin), .cfgRef(cfgRef), .inData(inData),
    .evalStart(evalStart), .outValid(outValid), .outBits(outBits),
    .neuronSum(neuronSum)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sumOf(int i);
    return int'($signed(neuronSum[i*GW +: GW]));
  endfunction

  function automatic int rawOf(int b);
    int m = 0;
    for (int k = 0; k < CONN; k++) if (iM[b][k] == wM[b][k]) m++;
    return 2 * m - CONN;
  endfunction

  function automatic logic [CONN-1:0] ones(int n);
    logic [CONN-1:0] v = '0;
    for (int k = 0; k < n; k++) v[k] = 1'b1;
    return v;
  endfunction

  // Expected totals in eighths, from the requirements
  function automatic void buildExp();
    int sc [NB];
    int b, e, s;
    for (int k = 0; k < NB; k++) sc[k] = (rawOf(k) * 8) / (1 << scM[k]);
    b = 0;
    while (b < NB) begin
      e = b;
      while (e < NB - 1 && jM[e]) e++;
      s = 0;
      for (int k = b; k <= e; k++) s += sc[k];
      for (int k = b; k <= e; k++) expTot[k] = s;
      b = e + 1;
    end
    for (int k = 0; k < NB; k++) expOut[k] = (expTot[k] >= refM[k]) ? 1 : 0;
  endfunction

  task automatic checkAll(string req);
    for (int i = 0; i < NB; i++) begin
      chk(req, $sformatf("sum[%0d]", i), sumOf(i), expTot[i]);
      chk(req, $sformatf("bit[%0d]", i), int'(outBits[i]), expOut[i]);
    end
  endtask

  task automatic wrWeight(int b, logic [CONN-1:0] d);
    wgtWrEn = 1'b1; wgtWrBlk = BIW'(b); wgtWrData = d;
    @(negedge clk);
    wgtWrEn = 1'b0;
    wM[b] = d;
  endtask

  task automatic wrCfg(int b, int sc, bit jn, int rf);
    cfgWrEn = 1'b1; cfgWrBlk = BIW'(b); cfgScale = 2'(sc);
    cfgJoin = jn; cfgRef = GW'(rf);
    @(negedge clk);
    cfgWrEn = 1'b0;
    scM[b] = sc; jM[b] = jn; refM[b] = rf;
  endtask

  task automatic setIn(int b, logic [CONN-1:0] d);
    inData[b*CONN +: CONN] = d;
    iM[b] = d;
  endtask

  task automatic clearCfg();
    for (int b = 0; b < NB; b++) wrCfg(b, 0, 1'b0, 0);
  endtask

  task automatic evalCheck(string req);
    buildExp();
    evalStart = 1'b1;
    @(negedge clk);
    evalStart = 1'b0;
    @(negedge clk);
    chk(req, "outValid high", int'(outValid), 1);
    checkAll(req);
    @(negedge clk);
    chk(req, "outValid pulse", int'(outValid), 0);
  endtask

  // R10: reset state and reset weight/config contents
  task automatic t_reset();
    chk("R10", "outValid in reset", int'(outValid), 0);
    chk("R10", "outBits in reset", int'(outBits), 0);
    chk("R10", "neuronSum in reset", (neuronSum == '0) ? 1 : 0, 1);
    rstN = 1'b1;
    @(negedge clk);
    // All weights 0 and inputs 0: every connection matches, +128 each
    evalCheck("R10");
    chk("R10", "default unit total", sumOf(5), 1024);
    chk("R10", "default bits", int'(outBits), 8'hFF);
  endtask

  // R1: encoding and dot product
  task automatic t_encoding();
    clearCfg();
    wrWeight(0, '1); setIn(0, '1);
    wrWeight(1, '1); setIn(1, '0);
    wrWeight(2, {64{2'b10}}); setIn(2, '1);
    wrWeight(3, '1); setIn(3, ones(37));
    wrWeight(4, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210); setIn(4, 128'hDEAD_BEEF_0000_FFFF_1234_5678_9ABC_DEF0);
    wrWeight(5, '0); setIn(5, '1);
    wrWeight(6, '0); setIn(6, ones(1));
    wrWeight(7, ones(127)); setIn(7, ones(127));
    evalCheck("R1");
    chk("R1", "all match", sumOf(0), 1024);
    chk("R1", "all mismatch", sumOf(1), -1024);
    chk("R1", "half match", sumOf(2), 0);
    chk("R1", "37 matches", sumOf(3), -54 * 8);
    chk("R1", "one mismatch", sumOf(6), 126 * 8);
  endtask

  // R3: scale codes on positive and negative sums
  task automatic t_scale();
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, '1);
      setIn(b, (b < 4) ? ones(100) : ones(10));
      wrCfg(b, b % 4, 1'b0, 0);
    end
    evalCheck("R3");
    chk("R3", "x1 pos", sumOf(0), 576);
    chk("R3", "x1/2 pos", sumOf(1), 288);
    chk("R3", "x1/4 pos", sumOf(2), 144);
    chk("R3", "x1/8 pos", sumOf(3), 72);
    chk("R3", "x1/4 neg", sumOf(6), -216);
    chk("R3", "x1/8 neg", sumOf(7), -108);
  endtask

  // R4: chained runs; chain bit of last unit ignored
  task automatic t_join();
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, ones(16 * b + 3));
      setIn(b, ones(40 + 9 * b));
    end
    wrCfg(0, 0, 1'b1, 0); wrCfg(1, 1, 1'b1, 0); wrCfg(2, 0, 1'b0, 0);
    wrCfg(3, 2, 1'b0, 0); wrCfg(4, 0, 1'b0, 0); wrCfg(5, 0, 1'b1, 0);
    wrCfg(6, 3, 1'b0, 0); wrCfg(7, 0, 1'b1, 0);
    evalCheck("R4");
    chk("R4", "run 0..2 shared", sumOf(0), sumOf(2));
    chk("R4", "run 5..6 shared", sumOf(5), sumOf(6));
    chk("R4", "last unit alone", sumOf(7), rawOf(7) * 8);
  endtask

  // R5: whole array as one long neuron
  task automatic t_long();
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, '1); setIn(b, '1);
      wrCfg(b, 0, (b < NB - 1), 0);
    end
    evalCheck("R5");
    chk("R5", "full match total", sumOf(3), 8 * NB * CONN);
    setIn(2, '0); setIn(6, ones(64));
    evalCheck("R5");
  endtask

  // R3: 4-bit weights from four units with binary scales
  task automatic t_multibit();
    clearCfg();
    for (int b = 0; b < 4; b++) begin
      setIn(b, 128'hF0F0_3C3C_AAAA_5555_FFFF_0000_1357_9BDF);
      wrCfg(b, b, (b < 3), 0);
    end
    wrWeight(0, 128'hF0F0_3C3C_AAAA_5555_0000_0000_0000_0000);
    wrWeight(1, 128'h0F0F_3C3C_AAAA_5555_FFFF_0000_1357_9BDF);
    wrWeight(2, '0);
    wrWeight(3, '1);
    for (int b = 4; b < NB; b++) begin
      wrWeight(b, '0); setIn(b, ones(b * 20));
    end
    evalCheck("R3");
  endtask

  // R6: threshold boundary, signed
  task automatic t_compare();
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, '1); setIn(b, ones(30 + 12 * b));
    end
    for (int b = 0; b < NB; b++) wrCfg(b, 0, 1'b0, 0);
    for (int b = 0; b < NB; b++) refM[b] = rawOf(b) * 8;
    wrCfg(0, 0, 1'b0, refM[0]);
    wrCfg(1, 0, 1'b0, refM[1] + 1);
    wrCfg(2, 0, 1'b0, refM[2] - 1);
    wrCfg(3, 0, 1'b0, -2000);
    wrCfg(4, 0, 1'b0, 2000);
    wrCfg(5, 2, 1'b0, refM[5] / 4);
    wrCfg(6, 3, 1'b0, (refM[6] / 8) + 1);
    wrCfg(7, 0, 1'b0, -1024);
    evalCheck("R6");
    chk("R6", "equal -> 1", int'(outBits[0]), 1);
    chk("R6", "one eighth above -> 0", int'(outBits[1]), 0);
  endtask

  // R11: thermometer code on a shared total
  task automatic t_thermo();
    int t;
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, 128'h5A5A_5A5A_0000_FFFF_1111_2222_3333_4444);
      setIn(b, ones(20 * b + 5));
      scM[b] = 0; jM[b] = (b < NB - 1);
    end
    buildExp();
    t = expTot[0];
    for (int b = 0; b < NB; b++) wrCfg(b, 0, (b < NB - 1), t + (b - 4) * 8);
    evalCheck("R11");
    chk("R11", "thermometer code", int'(outBits), 8'h1F);
  endtask

  // R7: back-to-back starts
  task automatic t_pipeline();
    clearCfg();
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, '1); setIn(b, ones(b * 16));
    end
    buildExp();
    for (int b = 0; b < NB; b++) begin keepTot[b] = expTot[b]; keepOut[b] = expOut[b]; end
    evalStart = 1'b1;
    @(negedge clk);
    for (int b = 0; b < NB; b++) setIn(b, ones(128 - b * 16));
    buildExp();
    @(negedge clk);
    evalStart = 1'b0;
    chk("R7", "first valid", int'(outValid), 1);
    for (int b = 0; b < NB; b++) chk("R7", $sformatf("first sum[%0d]", b), sumOf(b), keepTot[b]);
    @(negedge clk);
    chk("R7", "second valid", int'(outValid), 1);
    checkAll("R7");
    @(negedge clk);
    chk("R7", "valid drops", int'(outValid), 0);
  endtask

  // R8: results hold between evaluations
  task automatic t_hold();
    evalCheck("R8");
    for (int b = 0; b < NB; b++) setIn(b, ~iM[b]);
    wrWeight(2, '0);
    wrCfg(4, 1, 1'b1, 500);
    repeat (4) @(negedge clk);
    chk("R8", "valid stays low", int'(outValid), 0);
    checkAll("R8");
  endtask

  // R9: weight write on the start edge is not seen by that evaluation
  task automatic t_collide();
    clearCfg();
    for (int b = 0; b < NB; b++) begin
      wrWeight(b, '1); setIn(b, '1);
    end
    buildExp();
    wgtWrEn = 1'b1; wgtWrBlk = 3'd3; wgtWrData = '0;
    evalStart = 1'b1;
    @(negedge clk);
    wgtWrEn = 1'b0; evalStart = 1'b0;
    wM[3] = '0;
    @(negedge clk);
    chk("R9", "valid", int'(outValid), 1);
    chk("R9", "old weights used", sumOf(3), 1024);
    checkAll("R9");
    @(negedge clk);
    evalCheck("R9");
    chk("R9", "new weights used", sumOf(3), -1024);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      wM[b] = '0; iM[b] = '0; scM[b] = 0; jM[b] = 1'b0; refM[b] = 0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_encoding();
    t_scale();
    t_join();
    t_long();
    t_multibit();
    t_compare();
    t_thermo();
    t_pipeline();
    t_hold();
    t_collide();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

endmodule